// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block makes the stall and bubble decisions for the fetch, decode and execute pipeline registers of a five-stage in-order pipeline. The five stages are fetch, decode, execute, memory and writeback. It looks at four things: the instruction codes held in decode, execute and memory; the memory-result destination register of the execute-stage instruction; the two source registers that decode is reading; and the branch outcome that execute has computed. From these it derives three hazard conditions: a load followed by a use of its result, a return instruction moving down the pipe, and a conditional jump that was predicted wrongly. It combines them with a fixed priority, so that hazards arriving in the same cycle are resolved correctly.

The control outputs are computed combinationally from the current stage contents and take effect at the next clock edge. A thin registered wrapper holds the decode, execute and memory stage contents. The wrapper applies the control to those contents: a stall holds a stage, and a bubble loads a no-operation with no registers. This makes the hazard sequences visible cycle by cycle at the ports.

Instruction codes are parameters. Their defaults are no-operation 1, load 5, pop 11, conditional jump 7 and return 9. Register IDs are 4 bits wide, and ID 15 is reserved to mean "no register".

Top module: `pipe_hazard_ctl`

## Requirements
- R1: A synchronous active-low reset loads every stage code with no-operation (1) and every register field with ID 15. While the stages hold only no-operations, all four control outputs and `ctl_err` read low.
- R2: A load/use hazard exists when the execute code is load (5) or pop (11) and its destination register equals decode source A or decode source B. When it does, `f_stall`, `d_stall` and `e_bubble` are high and `d_bubble` is low. The dependent instruction stays in decode for exactly one extra cycle while execute receives a no-operation.
- R3: Register ID 15 never matches. A load whose destination is 15 causes no stall, even when a decode source is also 15.
- R4: While a return (9) is in decode, execute or memory, `f_stall` and `d_bubble` are high. One return therefore produces three consecutive stalled cycles.
- R5: When execute holds a conditional jump (7) and `ex_taken` is low, `d_bubble` and `e_bubble` are high and `f_stall` is low. Both wrong-path instructions are replaced by no-operations at the next edge. When `ex_taken` is high, the jump raises no control output.
- R6: A mispredicted jump in execute with a return in decode is handled as a mispredict. Both bubbles are raised, the fetch stall raised by the return is tolerated, and the return never reaches execute.
- R7: Load/use takes priority over return handling. With a return in decode that depends on a load in execute, `d_bubble` is low and `d_stall` is high. The return stays in decode for one extra cycle and then takes its three stalled cycles.
- R8: `ctl_err` goes high only if a stall and a bubble are raised together on the same pipeline register. Under every legal hazard combination, including those of R6 and R7, it stays low.
- R9: In any cycle with `f_stall` high, the presented `in_code` never enters decode.
- R10: The controls follow the current stage contents and `ex_taken` in the same cycle. The stage registers move only at the clock edge: a stall holds the stage, and a bubble loads no-operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_code | input | 4 | Instruction code entering decode at the next edge |
| in_src_a | input | 4 | Source register A of the entering instruction (15 = none) |
| in_src_b | input | 4 | Source register B of the entering instruction (15 = none) |
| in_dst_m | input | 4 | Memory-result destination of the entering instruction (15 = none) |
| ex_taken | input | 1 | Branch condition computed for the execute-stage instruction |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load no-operation into the decode register |
| e_bubble | output | 1 | Load no-operation into the execute register |
| ctl_err | output | 1 | Stall and bubble requested on the same register |
| d_code | output | 4 | Instruction code in decode |
| e_code | output | 4 | Instruction code in execute |
| m_code | output | 4 | Instruction code in memory |

## Verification
Load/use is tried with the match on source A, with the match on source B using a pop, and with both registers set to the reserved ID. Together these separate a correct comparator from one that ignores one port or lets "no register" match. A lone return is stepped through all three stages, and a jump is run both taken and not taken, so that the bubble pair is shown to depend on the outcome. The two same-cycle combinations are then run: a not-taken jump ahead of a return, and a return that depends on a load. They show that the mispredict wins in the first case and that load/use overrides the return bubble in the second. A marker code is presented on every stalled cycle so that any leak of fetch into decode shows up.

// File: rtl/hzd_pkg.sv
// Package: hzd_pkg
// Shared control bundle for the hazard unit. One stall and one bubble
// request per guarded pipeline register (fetch, decode, execute).
// Assumes: consumers treat bubble as "load no-operation" and stall as "hold".
package hzd_pkg;

    typedef struct packed {
        logic f_stall;
        logic f_bubble;
        logic d_stall;
        logic d_bubble;
        logic e_stall;
        logic e_bubble;
    } hzd_ctl_t;

endpackage

// File: rtl/hzd_detect.sv
// Module: hzd_detect
// Derives the three raw hazard conditions from stage contents:
// load/use, mispredicted jump in execute, and return in flight.
// Assumes: NONE_ID marks an unused register field and must never match.
module hzd_detect #(
    parameter int                CW       = 4,
    parameter int                RW       = 4,
    parameter logic [CW-1:0]     OP_LOAD  = 4'h5,
    parameter logic [CW-1:0]     OP_POP   = 4'hB,
    parameter logic [CW-1:0]     OP_JXX   = 4'h7,
    parameter logic [CW-1:0]     OP_RET   = 4'h9,
    parameter logic [RW-1:0]     NONE_ID  = '1
) (
    input  logic [CW-1:0] d_code,
    input  logic [RW-1:0] d_src_a,
    input  logic [RW-1:0] d_src_b,
    input  logic [CW-1:0] e_code,
    input  logic [RW-1:0] e_dst_m,
    input  logic [CW-1:0] m_code,
    input  logic          ex_taken,
    output logic          load_use,
    output logic          mispredict,
    output logic          ret_busy
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][RW-1:0] srcs;
    logic [NSRC-1:0]         src_hit;
    logic                    e_is_mem_rd;

    assign srcs = {d_src_b, d_src_a};

    // One comparator per decode source port.
    for (genvar i = 0; i < NSRC; i++) begin : g_src_cmp
        always_comb begin
            // Purpose: does this source port read the pending memory result?
            src_hit[i] = (srcs[i] == e_dst_m) && (e_dst_m != NONE_ID);
        end
    end

    always_comb begin
        // Purpose: execute-stage instruction produces its result from memory.
        e_is_mem_rd = (e_code == OP_LOAD) || (e_code == OP_POP);
    end

    always_comb begin
        // Purpose: combine into the three raw hazard conditions.
        load_use   = e_is_mem_rd && (|src_hit);
        mispredict = (e_code == OP_JXX) && !ex_taken;
        ret_busy   = (d_code == OP_RET) || (e_code == OP_RET) || (m_code == OP_RET);
    end

endmodule

// File: rtl/hzd_ctl.sv
// Module: hzd_ctl
// Maps raw hazard conditions to per-register stall/bubble requests with
// fixed priority: load/use overrides the return bubble in decode; a
// mispredict bubbles decode and execute whatever else holds.
// Assumes: load_use and mispredict cannot both be high (distinct opcodes).
module hzd_ctl
    import hzd_pkg::*;
(
    input  logic     load_use,
    input  logic     mispredict,
    input  logic     ret_busy,
    output hzd_ctl_t ctl,
    output logic     err
);

    always_comb begin
        // Purpose: priority combination of hazard conditions.
        ctl          = '0;
        ctl.f_stall  = load_use || ret_busy;
        ctl.d_stall  = load_use;
        ctl.d_bubble = mispredict || (ret_busy && !load_use);
        ctl.e_bubble = mispredict || load_use;
    end

    always_comb begin
        // Purpose: flag any register asked to both hold and clear.
        err = (ctl.f_stall && ctl.f_bubble) ||
              (ctl.d_stall && ctl.d_bubble) ||
              (ctl.e_stall && ctl.e_bubble);
    end

endmodule

// File: rtl/hzd_pipe_reg.sv
// Module: hzd_pipe_reg
// One pipeline stage register with hold (stall) and clear-to-idle (bubble).
// Assumes: synchronous active-low reset; bubble wins over stall.
module hzd_pipe_reg #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   IDLE    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stall,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        // Purpose: load, hold or clear the stage contents.
        if (!rst_n)       q <= IDLE;
        else if (bubble)  q <= IDLE;
        else if (!stall)  q <= d;
    end

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !bubble) |=> $stable(q));

    assert_bubble_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (q == IDLE));

endmodule

// File: rtl/pipe_hazard_ctl.sv
// Module: pipe_hazard_ctl
// Hazard control for a five-stage in-order pipeline, wrapped with the
// decode/execute/memory stage registers it governs so the effect of each
// decision is visible at the ports one edge later.
// Assumes: the fetch register (PC) lives outside; f_stall is exported only.
module pipe_hazard_ctl
    import hzd_pkg::*;
#(
    parameter int             CW       = 4,
    parameter int             RW       = 4,
    parameter logic [CW-1:0]  OP_NOP   = 4'h1,
    parameter logic [CW-1:0]  OP_LOAD  = 4'h5,
    parameter logic [CW-1:0]  OP_POP   = 4'hB,
    parameter logic [CW-1:0]  OP_JXX   = 4'h7,
    parameter logic [CW-1:0]  OP_RET   = 4'h9,
    parameter logic [RW-1:0]  NONE_ID  = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] in_code,
    input  logic [RW-1:0] in_src_a,
    input  logic [RW-1:0] in_src_b,
    input  logic [RW-1:0] in_dst_m,
    input  logic          ex_taken,
    output logic          f_stall,
    output logic          d_stall,
    output logic          d_bubble,
    output logic          e_bubble,
    output logic          ctl_err,
    output logic [CW-1:0] d_code,
    output logic [CW-1:0] e_code,
    output logic [CW-1:0] m_code
);
    localparam int DW = CW + 3 * RW;
    localparam int EW = CW + RW;
    localparam logic [DW-1:0] D_IDLE = {OP_NOP, NONE_ID, NONE_ID, NONE_ID};
    localparam logic [EW-1:0] E_IDLE = {OP_NOP, NONE_ID};

    logic [DW-1:0] d_q;
    logic [EW-1:0] e_q;
    logic [RW-1:0] d_src_a, d_src_b, d_dst_m, e_dst_m;
    logic          load_use, mispredict, ret_busy;
    hzd_ctl_t      ctl;

    assign {d_code, d_src_a, d_src_b, d_dst_m} = d_q;
    assign {e_code, e_dst_m}                   = e_q;

    hzd_detect #(
        .CW(CW), .RW(RW), .OP_LOAD(OP_LOAD), .OP_POP(OP_POP),
        .OP_JXX(OP_JXX), .OP_RET(OP_RET), .NONE_ID(NONE_ID)
    ) detect_i (
        .d_code     (d_code),
        .d_src_a    (d_src_a),
        .d_src_b    (d_src_b),
        .e_code     (e_code),
        .e_dst_m    (e_dst_m),
        .m_code     (m_code),
        .ex_taken   (ex_taken),
        .load_use   (load_use),
        .mispredict (mispredict),
        .ret_busy   (ret_busy)
    );

    hzd_ctl ctl_i (
        .load_use   (load_use),
        .mispredict (mispredict),
        .ret_busy   (ret_busy),
        .ctl        (ctl),
        .err        (ctl_err)
    );

    // Decode stage register: code plus the three register fields.
    hzd_pipe_reg #(.W(DW), .IDLE(D_IDLE)) dreg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (ctl.d_stall),
        .bubble (ctl.d_bubble),
        .d      ({in_code, in_src_a, in_src_b, in_dst_m}),
        .q      (d_q)
    );

    // Execute stage register: code and memory-result destination.
    hzd_pipe_reg #(.W(EW), .IDLE(E_IDLE)) ereg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (ctl.e_stall),
        .bubble (ctl.e_bubble),
        .d      ({d_code, d_dst_m}),
        .q      (e_q)
    );

    // Memory stage register: code only, never stalled or bubbled here.
    hzd_pipe_reg #(.W(CW), .IDLE(OP_NOP)) mreg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (1'b0),
        .bubble (1'b0),
        .d      (e_code),
        .q      (m_code)
    );

    assign f_stall  = ctl.f_stall;
    assign d_stall  = ctl.d_stall;
    assign d_bubble = ctl.d_bubble;
    assign e_bubble = ctl.e_bubble;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (d_code == OP_NOP && e_code == OP_NOP && m_code == OP_NOP));

    assert_ret_holds_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_code == OP_RET || m_code == OP_RET) |-> (f_stall && (d_bubble || d_stall)));

    assert_mispredict_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (e_code == OP_JXX && !ex_taken) |=> (d_code == OP_NOP && e_code == OP_NOP));

    assert_loaduse_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        d_stall |=> ($stable(d_code) && e_code == OP_NOP));

    assert_no_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_err);

    assert_fetch_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        f_stall |=> (d_code == $past(d_code) || d_code == OP_NOP));

endmodule

// File: tb/pipe_hazard_ctl_tb_top.sv
// Directed bench for pipe_hazard_ctl: one task per hazard scenario.
module pipe_hazard_ctl_tb_top;

    localparam logic [3:0] NOP  = 4'h1;
    localparam logic [3:0] MARK = 4'h2;
    localparam logic [3:0] IRM  = 4'h3;
    localparam logic [3:0] LD   = 4'h5;
    localparam logic [3:0] OPQ  = 4'h6;
    localparam logic [3:0] JXX  = 4'h7;
    localparam logic [3:0] RET  = 4'h9;
    localparam logic [3:0] POP  = 4'hB;
    localparam logic [3:0] N    = 4'hF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in_code = NOP, in_src_a = N, in_src_b = N, in_dst_m = N;
    logic       ex_taken = 1'b0;
    logic       f_stall, d_stall, d_bubble, e_bubble, ctl_err;
    logic [3:0] d_code, e_code, m_code;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pipe_hazard_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_code(in_code), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_dst_m(in_dst_m), .ex_taken(ex_taken),
        .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
        .e_bubble(e_bubble), .ctl_err(ctl_err),
        .d_code(d_code), .e_code(e_code), .m_code(m_code)
    );

    // Compare {f_stall,d_stall,d_bubble,e_bubble}, ctl_err and stage codes.
    task automatic chk(input string req, input logic [3:0] ctl_exp,
                       input logic [3:0] dc, input logic [3:0] ec, input logic [3:0] mc);
        logic [3:0] ctl_act;
        ctl_act = {f_stall, d_stall, d_bubble, e_bubble};
        checks++;
        if (ctl_act !== ctl_exp || ctl_err !== 1'b0 ||
            d_code !== dc || e_code !== ec || m_code !== mc) begin
            fails++;
            $display("FAIL %s: ctl=%b err=%b codes=%h/%h/%h expected ctl=%b err=0 codes=%h/%h/%h",
                     req, ctl_act, ctl_err, d_code, e_code, m_code, ctl_exp, dc, ec, mc);
        end
    endtask

    // Present one instruction just after a falling edge; previous edge has passed.
    task automatic drv(input logic [3:0] c, input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] dm, input logic tk);
        @(negedge clk);
        in_code = c; in_src_a = a; in_src_b = b; in_dst_m = dm; ex_taken = tk;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_code = NOP; in_src_a = N; in_src_b = N; in_dst_m = N; ex_taken = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 reset idle", 4'b0000, NOP, NOP, NOP);
        rst_n = 1'b1;
    endtask

    task automatic t_load_use();
        do_reset();
        drv(LD, N, N, 4'h3, 0);
        drv(OPQ, 4'h3, N, N, 0);
        chk("R10 load in decode, no hazard yet", 4'b0000, LD, NOP, NOP);
        drv(MARK, N, N, N, 0);
        chk("R2 load/use on source A", 4'b1101, OPQ, LD, NOP);
        drv(IRM, N, N, N, 0);
        chk("R2 R9 consumer held, execute bubbled", 4'b0000, OPQ, NOP, LD);
        drv(NOP, N, N, N, 0);
        chk("R10 pipeline resumes", 4'b0000, IRM, OPQ, NOP);
        do_reset();
        drv(POP, N, N, 4'h6, 0);
        drv(OPQ, N, 4'h6, N, 0);
        drv(MARK, N, N, N, 0);
        chk("R2 pop/use on source B", 4'b1101, OPQ, POP, NOP);
    endtask

    task automatic t_none_id();
        do_reset();
        drv(LD, N, N, N, 0);
        drv(OPQ, N, N, N, 0);
        drv(NOP, N, N, N, 0);
        chk("R3 reserved id never matches", 4'b0000, OPQ, LD, NOP);
    endtask

    task automatic t_ret();
        do_reset();
        drv(RET, 4'h4, N, N, 0);
        drv(MARK, N, N, N, 0);
        chk("R4 return in decode", 4'b1010, RET, NOP, NOP);
        drv(MARK, N, N, N, 0);
        chk("R4 R9 return in execute", 4'b1010, NOP, RET, NOP);
        drv(MARK, N, N, N, 0);
        chk("R4 R9 return in memory", 4'b1010, NOP, NOP, RET);
        drv(OPQ, N, N, N, 0);
        chk("R4 return gone, stalls end", 4'b0000, NOP, NOP, NOP);
        drv(NOP, N, N, N, 0);
        chk("R4 fetch resumes", 4'b0000, OPQ, NOP, NOP);
    endtask

    task automatic t_jump();
        do_reset();
        drv(JXX, N, N, N, 0);
        drv(OPQ, N, N, N, 0);
        drv(IRM, N, N, N, 0);
        chk("R5 mispredict bubbles", 4'b0011, OPQ, JXX, NOP);
        drv(NOP, N, N, N, 0);
        chk("R5 wrong path cancelled", 4'b0000, NOP, NOP, JXX);
        do_reset();
        drv(JXX, N, N, N, 1);
        drv(OPQ, N, N, N, 1);
        drv(IRM, N, N, N, 1);
        chk("R5 taken jump no bubble", 4'b0000, OPQ, JXX, NOP);
        drv(NOP, N, N, N, 1);
        chk("R5 taken jump path kept", 4'b0000, IRM, OPQ, JXX);
    endtask

    task automatic t_combo_a();
        do_reset();
        drv(JXX, N, N, N, 0);
        drv(RET, 4'h4, N, N, 0);
        drv(MARK, N, N, N, 0);
        chk("R6 R8 mispredict over return", 4'b1011, RET, JXX, NOP);
        drv(OPQ, N, N, N, 0);
        chk("R6 return cancelled", 4'b0000, NOP, NOP, JXX);
        drv(NOP, N, N, N, 0);
        chk("R6 correct path fetched", 4'b0000, OPQ, NOP, NOP);
    endtask

    task automatic t_combo_b();
        do_reset();
        drv(LD, N, N, 4'h4, 0);
        drv(RET, 4'h4, N, N, 0);
        drv(MARK, N, N, N, 0);
        chk("R7 R8 load/use beats return bubble", 4'b1101, RET, LD, NOP);
        drv(MARK, N, N, N, 0);
        chk("R7 return held one more cycle", 4'b1010, RET, NOP, LD);
        drv(MARK, N, N, N, 0);
        chk("R7 return in execute", 4'b1010, NOP, RET, NOP);
        drv(MARK, N, N, N, 0);
        chk("R7 return in memory", 4'b1010, NOP, NOP, RET);
        drv(OPQ, N, N, N, 0);
        chk("R7 R9 sequence done", 4'b0000, NOP, NOP, NOP);
    endtask

    initial begin
        t_load_use();
        t_none_id();
        t_ret();
        t_jump();
        t_combo_a();
        t_combo_b();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule